// File: doc/BRIEF.md
# Low-Speed Timekeeping Clock Selector

This block produces the slow timebase for a timekeeping unit. It can take that timebase from one of two sources. The first is an internal RC oscillator, which arrives as a one-cycle tick in the system clock domain. The second is an external crystal clock, which arrives asynchronously. On the internal path the ticks pass through a divider that is fixed at build time and then through a divider that software programs. The external path is synchronised and edge-detected, and it is not divided. The result is a one-cycle enable pulse, `tick_o`, at the selected rate. A second output, `pin_tick_o`, is a copy of that pulse that software can gate off before it reaches a pad.

Software controls the block through a small word-wide register port. The control word is guarded by a 16-bit key: a write without the key is dropped.

A missing-edge watchdog watches the external source while that source is requested. If no edge arrives for `TIMEOUT` system cycles, the hardware returns the request to the internal oscillator, unless software has set the bypass bit. The source actually in use changes only on a terminal count of the newly requested path, so a changeover never produces a shortened interval.

Top module: `lsclk_sel`

## Requirements
- R1: A write to the control word (address 0) takes effect only when `reg_wdata_i[31:16]` equals 16'h16AA. Any other key value leaves the stored control word unchanged.
- R2: Reading the control word returns the source request in bit 0 (1 = external, 0 = internal), the external-oscillator enable in bit 4 and the fallback bypass in bit 15. All other bits read 0.
- R3: With the internal source in use, `tick_o` pulses once every `PRE_DIV`*(P+1) internal ticks. P is bits 4:0 of the prescaler word (address 1), and the other bits of that word read 0.
- R4: With the external source in use, `tick_o` pulses once for each rising edge of `ext_clk_i`, with no division.
- R5: The source in use changes only on a cycle in which the newly requested path reaches its terminal count. The interval that spans a changeover is therefore never shorter than the new source's period.
- R6: When the external source is requested, bypass is 0, and `ext_clk_i` shows no rising edge for `TIMEOUT` cycles, the hardware clears the request bit. Ticks then resume at the internal rate.
- R7: When bypass is 1, a missing external clock leaves the request bit set and does not cause a switch to the internal source.
- R8: `pin_tick_o` equals `tick_o` while bit 0 of the gate word (address 2) is 1, and it stays 0 while that bit is 0. The gate word reads back its bit 0 only.
- R9: After reset, all three registers read 0, and the internal source is in use.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_osc_tick_i | input | 1 | One-cycle tick per internal oscillator period |
| ext_clk_i | input | 1 | External low-speed clock, asynchronous |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Word address: 0 control, 1 prescaler, 2 gate |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from the address |
| tick_o | output | 1 | Timebase enable pulse |
| pin_tick_o | output | 1 | Gated copy of the enable pulse for a pad |

## Verification
Register read data is valid in the same cycle as the address, and a write is visible from the cycle after its clock edge. An internal terminal count appears on `tick_o` one edge later. An external rising edge appears on `tick_o` three edges later: two synchroniser stages and one output register. The fallback clears the request bit one edge after the `TIMEOUT`-th cycle without an edge. Because these latencies are fixed, the bench samples at falling edges and judges the rate by the spacing between consecutive ticks; the constant delays cancel out of that measurement. For the fallback case, the bench reads back the control word only after waiting well beyond `TIMEOUT` cycles.

// File: rtl/lsclk_pkg.sv
package lsclk_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned ADDR_W   = 2;
  localparam int unsigned PRESC_W  = 5;
  localparam logic [15:0] CTRL_KEY = 16'h16AA;

  localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PRESC = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_GATE  = 2'd2;

  localparam int unsigned BIT_SEL    = 0;
  localparam int unsigned BIT_EXT_EN = 4;
  localparam int unsigned BIT_BYPASS = 15;

  typedef struct packed {
    logic bypass;
    logic ext_en;
    logic sel;
  } ctrl_t;
endpackage

// File: rtl/lsclk_int_div.sv
module lsclk_int_div
  import lsclk_pkg::*;
#(
  parameter int unsigned PRE_DIV = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tc_o
);
  logic               pre_last;
  logic [PRESC_W-1:0] post_q;
  logic               post_wrap;

  generate
    if (PRE_DIV <= 1) begin : g_no_pre
      assign pre_last = 1'b1;
    end else begin : g_pre
      localparam int unsigned CW = $clog2(PRE_DIV);
      logic [CW-1:0] pre_q;
      assign pre_last = (pre_q == CW'(PRE_DIV - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     pre_q <= '0;
        else if (tick_i) pre_q <= pre_last ? '0 : pre_q + 1'b1;
      end
    end
  endgenerate

  // >= so that lowering P while counting still wraps
  assign post_wrap = (post_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 post_q <= '0;
    else if (tick_i && pre_last) post_q <= post_wrap ? '0 : post_q + 1'b1;
  end

  assign tc_o = tick_i & pre_last & post_wrap;
endmodule

// File: rtl/lsclk_ext_mon.sv
module lsclk_ext_mon #(
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_clk_i,
  input  logic arm_i,
  output logic rise_o,
  output logic fail_o
);
  localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;

  logic          s1_q, s2_q, prev_q;
  logic [CW-1:0] cnt_q;
  logic          cnt_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b0;
      s2_q   <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= ext_clk_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o   = s2_q & ~prev_q;
  assign cnt_last = (cnt_q == CW'(TIMEOUT - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!arm_i || rise_o)      cnt_q <= '0;
    else if (cnt_last)              cnt_q <= '0;
    else                            cnt_q <= cnt_q + 1'b1;
  end

  assign fail_o = arm_i & ~rise_o & cnt_last;
endmodule

// File: rtl/lsclk_regs.sv
module lsclk_regs
  import lsclk_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               fail_i,
  output ctrl_t              ctrl_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic               gate_o,
  output logic [DATA_W-1:0]  rdata_o
);
  logic ctrl_wr, presc_wr, gate_wr;
  logic unused_wdata;

  assign ctrl_wr  = we_i && (addr_i == ADDR_CTRL) && (wdata_i[31:16] == CTRL_KEY);
  assign presc_wr = we_i && (addr_i == ADDR_PRESC);
  assign gate_wr  = we_i && (addr_i == ADDR_GATE);
  assign unused_wdata = ^{wdata_i[14:5], wdata_i[3:1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (ctrl_wr) begin
      ctrl_o.sel    <= wdata_i[BIT_SEL];
      ctrl_o.ext_en <= wdata_i[BIT_EXT_EN];
      ctrl_o.bypass <= wdata_i[BIT_BYPASS];
    end else if (fail_i && !ctrl_o.bypass) begin
      ctrl_o.sel    <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       presc_o <= '0;
    else if (presc_wr) presc_o <= wdata_i[PRESC_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gate_o <= 1'b0;
    else if (gate_wr) gate_o <= wdata_i[0];
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_CTRL: begin
        rdata_o[BIT_SEL]    = ctrl_o.sel;
        rdata_o[BIT_EXT_EN] = ctrl_o.ext_en;
        rdata_o[BIT_BYPASS] = ctrl_o.bypass;
      end
      ADDR_PRESC: rdata_o[PRESC_W-1:0] = presc_o;
      ADDR_GATE:  rdata_o[0]           = gate_o;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/lsclk_sel.sv
module lsclk_sel
  import lsclk_pkg::*;
#(
  parameter int unsigned PRE_DIV = 32,
  parameter int unsigned TIMEOUT = 1024
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              int_osc_tick_i,
  input  logic              ext_clk_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              tick_o,
  output logic              pin_tick_o
);
  ctrl_t              ctrl;
  logic [PRESC_W-1:0] presc;
  logic               gate_en;
  logic               int_tc, ext_rise, ext_fail;
  logic               act_sel_q, tick_q, pin_q;
  logic               tgt_tc, tick_d;

  lsclk_regs i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (reg_we_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .fail_i  (ext_fail),
    .ctrl_o  (ctrl),
    .presc_o (presc),
    .gate_o  (gate_en),
    .rdata_o (reg_rdata_o)
  );

  lsclk_int_div #(.PRE_DIV(PRE_DIV)) i_int_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (int_osc_tick_i),
    .presc_i (presc),
    .tc_o    (int_tc)
  );

  lsclk_ext_mon #(.TIMEOUT(TIMEOUT)) i_ext_mon (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ext_clk_i (ext_clk_i),
    .arm_i     (ctrl.sel),
    .rise_o    (ext_rise),
    .fail_o    (ext_fail)
  );

  // changeover waits for the requested path's terminal count
  assign tgt_tc = ctrl.sel ? ext_rise : int_tc;
  assign tick_d = act_sel_q ? ext_rise : int_tc;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_sel_q <= 1'b0;
      tick_q    <= 1'b0;
      pin_q     <= 1'b0;
    end else begin
      if (ctrl.sel != act_sel_q && tgt_tc) act_sel_q <= ctrl.sel;
      tick_q <= tick_d;
      pin_q  <= tick_d & gate_en;
    end
  end

  assign tick_o     = tick_q;
  assign pin_tick_o = pin_q;
endmodule

// File: rtl/lsclk_sel_chk.sv
module lsclk_sel_chk
  import lsclk_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [15:0]       key_i,
  input logic              tick_o,
  input logic              pin_tick_o,
  input logic              sel_req,
  input logic              ext_en,
  input logic              bypass,
  input logic              act_sel,
  input logic              ext_rise,
  input logic              int_tc,
  input logic              ext_fail
);
  logic ctrl_sel_wr, bad_key_wr;
  assign ctrl_sel_wr = reg_we_i && (reg_addr_i == ADDR_CTRL);
  assign bad_key_wr  = ctrl_sel_wr && (key_i != CTRL_KEY);

  a_r1_key_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_key_wr |=> $stable({ext_en, bypass}));

  a_r4_ext_pass: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel && ext_rise) |=> tick_o);

  a_r5_switch_at_tc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_sel != $past(act_sel)) |-> (act_sel ? $past(ext_rise) : $past(int_tc)));

  a_r6_fallback: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_fail && !bypass && !ctrl_sel_wr) |=> !sel_req);

  a_r7_bypass_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_fail && bypass && !ctrl_sel_wr) |=> sel_req);

  a_r8_pin_subset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_tick_o |-> tick_o);
endmodule

bind lsclk_sel lsclk_sel_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .reg_we_i   (reg_we_i),
  .reg_addr_i (reg_addr_i),
  .key_i      (reg_wdata_i[31:16]),
  .tick_o     (tick_o),
  .pin_tick_o (pin_tick_o),
  .sel_req    (ctrl.sel),
  .ext_en     (ctrl.ext_en),
  .bypass     (ctrl.bypass),
  .act_sel    (act_sel_q),
  .ext_rise   (ext_rise),
  .int_tc     (int_tc),
  .ext_fail   (ext_fail)
);

// File: tb/test_lsclk_sel.sv
module test_lsclk_sel;
  localparam int TMO = 64;
  localparam int NV  = 5;
  // {P, internal tick spacing, expected period in cycles}
  localparam int VEC [0:NV-1][0:2] = '{
    '{0, 1, 32}, '{3, 1, 128}, '{1, 2, 128}, '{31, 1, 1024}, '{7, 3, 768}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        int_osc_tick_i = 1'b0;
  logic        ext_clk_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        tick_o, pin_tick_o;

  int n_chk = 0, n_bad = 0;
  int int_sp = 1, ext_half = 0, k_int = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  lsclk_sel #(.PRE_DIV(32), .TIMEOUT(TMO)) i_lsclk_sel (.*);

  initial forever begin
    @(negedge clk_i);
    if (int_sp == 0) int_osc_tick_i = 1'b0;
    else begin
      int_osc_tick_i = (k_int % int_sp) == 0;
      k_int++;
    end
  end

  initial forever begin
    if (ext_half == 0) @(negedge clk_i);
    else begin
      repeat (ext_half) @(negedge clk_i);
      ext_clk_i = ~ext_clk_i;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic get_gap(output int gap);
    int n = 0;
    gap = -1;
    while (!tick_o && n < 4000) begin @(negedge clk_i); n++; end
    if (tick_o) begin
      @(negedge clk_i); n = 1;
      while (!tick_o && n < 4000) begin @(negedge clk_i); n++; end
      if (tick_o) gap = n;
    end
  endtask

  task automatic count_win(input int cyc, output int t, output int p);
    t = 0; p = 0;
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk_i);
      t += int'(tick_o);
      p += int'(pin_tick_o);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int g, t, p;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;

    // R9 reset state
    rd(2'd0, d); chk(d == 0, "R9 ctrl", int'(d), 0);
    rd(2'd1, d); chk(d == 0, "R9 presc", int'(d), 0);
    rd(2'd2, d); chk(d == 0, "R9 gate", int'(d), 0);
    get_gap(g); get_gap(g); chk(g == 32, "R9 internal after reset", g, 32);

    // R3 table of divider settings
    for (int v = 0; v < NV; v++) begin
      int_sp = VEC[v][1];
      wr(2'd1, 32'hFFFF_FFE0 | VEC[v][0]);
      rd(2'd1, d); chk(d == VEC[v][0], "R3 presc readback", int'(d), VEC[v][0]);
      get_gap(g); get_gap(g); get_gap(g);
      chk(g == VEC[v][2], "R3 period", g, VEC[v][2]);
    end
    int_sp = 1;
    wr(2'd1, 32'd0);
    get_gap(g);

    // R1 bad key ignored, R2 field layout
    wr(2'd0, 32'h16AB_8011);
    rd(2'd0, d); chk(d == 0, "R1 bad key", int'(d), 0);
    wr(2'd0, 32'h16AA_0010);
    rd(2'd0, d); chk(d == 32'h10, "R1 good key", int'(d), 32'h10);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0, d); chk(d == 32'h10, "R1 zero key", int'(d), 32'h10);

    // R4/R5 internal -> external, ext period 10
    ext_half = 5;
    repeat (30) @(negedge clk_i);
    wr(2'd0, 32'h16AA_FFFF);
    rd(2'd0, d); chk(d == 32'h8011, "R2 readback", int'(d), 32'h8011);
    for (int i = 0; i < 3; i++) begin
      get_gap(g); chk(g >= 10, "R5 int->ext gap", g, 10);
    end
    get_gap(g); chk(g == 10, "R4 external rate", g, 10);

    // R5 external -> internal
    wr(2'd0, 32'h16AA_0010);
    for (int i = 0; i < 6; i++) begin
      get_gap(g); chk(g == 10 || g >= 32, "R5 ext->int gap", g, 32);
    end
    get_gap(g); chk(g == 32, "R5 internal rate", g, 32);

    // R6 fallback on missing external clock
    wr(2'd0, 32'h16AA_0011);
    repeat (40) @(negedge clk_i);
    ext_half = 0;
    repeat (TMO + 40) @(negedge clk_i);
    rd(2'd0, d); chk(d == 32'h10, "R6 request cleared", int'(d), 32'h10);
    get_gap(g); get_gap(g); chk(g == 32, "R6 internal resumes", g, 32);

    // R7 bypass keeps external request
    ext_half = 5;
    wr(2'd0, 32'h16AA_8011);
    repeat (60) @(negedge clk_i);
    ext_half = 0;
    repeat (20) @(negedge clk_i);
    repeat (3 * TMO) @(negedge clk_i);
    rd(2'd0, d); chk(d == 32'h8011, "R7 request held", int'(d), 32'h8011);
    count_win(200, t, p); chk(t == 0, "R7 no internal ticks", t, 0);
    wr(2'd0, 32'h16AA_0000);
    get_gap(g); get_gap(g); chk(g == 32, "R7 manual return", g, 32);

    // R8 pad gate
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, d); chk(d == 1, "R8 gate readback", int'(d), 1);
    count_win(200, t, p);
    chk(t > 0 && p == t, "R8 gate on", p, t);
    wr(2'd2, 32'h0);
    count_win(200, t, p);
    chk(t > 0 && p == 0, "R8 gate off", p, 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule